// File: doc/BRIEF.md
# Page Hamming ECC engine

This block computes a single-error-correct, double-error-detect Hamming code for each 512-byte block of a NAND page while the page bytes stream through the controller. It starts on its own when a read or write command with a block-aligned address is presented. It counts bytes into consecutive blocks, up to four per page, and keeps one 24-bit code per finished block.

On a write, the block codes come out packed in block order. A spare-area writer then places them after the page data. On a read, the codes stored in the spare area are presented when the last-block flag is given. The engine forms a syndrome for every block and reports one of four conditions per block. For a correctable error it also reports the bit position. Repairing the buffered data is left to software.

The control state machine has four states:
- `ST_IDLE`: waiting for a command.
- `ST_RUN`: accumulating bytes.
- `ST_EVAL`: latching per-block status.
- `ST_DONE`: one-cycle completion.

Its transitions are:
- IDLE→RUN on an aligned command.
- RUN→EVAL on the last-block flag.
- EVAL→DONE always.
- DONE→RUN on an aligned command, otherwise DONE→IDLE.
- All other inputs leave the state unchanged.

Top module: `nand_page_ecc`

## Requirements
- R1: A command starts an operation only when `cmd_valid_i` is high, the engine is in IDLE or DONE, and `cmd_offs_i` is zero (512-byte aligned); `busy_o` is then high from the next cycle. A misaligned command is ignored and `busy_o` stays low.
- R2: A block's bit position is p = byte_index*8 + bit_index (12 bits). The block code holds, for each position bit k = 0..11, bit 2k = parity of all data bits whose position has bit k = 0, and bit 2k+1 = parity of those with bit k = 1. Block b's code sits at `code_o[24*b +: 24]`.
- R3: Bytes are grouped into blocks of 512. `blk_cnt_o` reports the number of completed blocks. Bytes of a trailing partial block are not part of any code.
- R4: Bytes arriving after four blocks are complete are ignored; codes and count are unchanged by them.
- R5: On a read, a block whose stored and computed codes match reports status 0 (clean) in `blk_stat_o[2*b +: 2]`.
- R6: When every one of the 12 syndrome bit pairs has exactly one bit set, the block reports status 1 (correctable). `err_loc_o[12*b +: 12]` then gives the flipped bit position p.
- R7: A syndrome with exactly one bit set reports status 3 (error in the stored code), with location 0.
- R8: Any other nonzero syndrome reports status 2 (uncorrectable), with location 0.
- R9: `last_i` in RUN ends the operation. `done_o` is high for exactly one cycle, two cycles after `last_i` is sampled. Status and codes stay held until the next accepted command.
- R10: On a write, all block status and location fields are zero at completion. Blocks not completed report zero code and zero status.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_write_i | input | 1 | 1 = write page, 0 = read page |
| cmd_offs_i | input | 9 | Address bits below the block size; must be zero to start |
| byte_valid_i | input | 1 | Data byte valid |
| byte_i | input | 8 | Data byte |
| last_i | input | 1 | Last-block flag, ends the operation |
| stored_code_i | input | 96 | Codes read from the spare area, sampled with `last_i` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| blk_cnt_o | output | 3 | Completed block count |
| code_o | output | 96 | Computed block codes |
| blk_stat_o | output | 8 | Per-block status, 2 bits each |
| err_loc_o | output | 48 | Per-block error bit position |

## Verification
Pages of different lengths and data seeds are streamed in write mode and in clean read mode. This separates a wrong code layout from a wrong block count. Read pages then carry injected faults:
- A single data flip at the first and at the last bit of a block, and in the middle of a block.
- Two flips in one block.
- A flipped bit in the stored code.

These faults distinguish the four status outcomes, and check that the reported location tracks both byte and bit index. Directed runs add a misaligned command, a trailing partial block and bytes beyond the fourth block. They confirm which bytes count.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [1:0] {
        BLK_CLEAN   = 2'd0,
        BLK_FIXABLE = 2'd1,
        BLK_BROKEN  = 2'd2,
        BLK_CODEERR = 2'd3
    } blk_stat_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EVAL = 2'd2,
        ST_DONE = 2'd3
    } ecc_state_e;

endpackage

// File: rtl/hamm_accum.sv
module hamm_accum #(
    parameter int IDX_W = 9,
    localparam int POS_W = IDX_W + 3,
    localparam int CODE_W = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [7:0]        byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_nxt_o
);
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] contrib;
    logic              byte_par;

    // Parity contribution of one byte: bit-index pairs from the byte's own
    // bits, byte-index pairs from the whole-byte parity.
    always_comb begin
        contrib  = '0;
        byte_par = ^byte_i;
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (((b >> k) & 1) == 1)
                    contrib[2*k+1] = contrib[2*k+1] ^ byte_i[b];
                else
                    contrib[2*k]   = contrib[2*k] ^ byte_i[b];
            end
        end
        for (int k = 0; k < IDX_W; k++) begin
            if (idx_i[k])
                contrib[2*(k+3)+1] = byte_par;
            else
                contrib[2*(k+3)]   = byte_par;
        end
        code_nxt_o = code_q ^ contrib;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_q <= '0;
        else if (clr_i)
            code_q <= '0;
        else if (en_i)
            code_q <= code_nxt_o;
    end

endmodule

// File: rtl/syn_decode.sv
module syn_decode
    import ecc_pkg::*;
#(
    parameter int POS_W = 12,
    localparam int CODE_W = 2 * POS_W
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output blk_stat_e         stat_o,
    output logic [POS_W-1:0]  loc_o
);
    logic [CODE_W-1:0] syn;
    logic [POS_W-1:0]  odd_bits;
    logic              pairs_split;

    always_comb begin
        syn         = calc_i ^ stored_i;
        pairs_split = 1'b1;
        for (int k = 0; k < POS_W; k++) begin
            if (syn[2*k] == syn[2*k+1])
                pairs_split = 1'b0;
            odd_bits[k] = syn[2*k+1];
        end
        if (syn == '0) begin
            stat_o = BLK_CLEAN;
            loc_o  = '0;
        end else if ($countones(syn) == 1) begin
            stat_o = BLK_CODEERR;
            loc_o  = '0;
        end else if (pairs_split) begin
            stat_o = BLK_FIXABLE;
            loc_o  = odd_bits;
        end else begin
            stat_o = BLK_BROKEN;
            loc_o  = '0;
        end
    end

    // R6: a correctable verdict needs a syndrome of exactly one bit per pair
    always_comb begin
        if (stat_o == BLK_FIXABLE)
            assert_fix_weight_R6: assert ($countones(calc_i ^ stored_i) == POS_W);
    end

    // R7: a code-error verdict needs a one-hot syndrome
    always_comb begin
        if (stat_o == BLK_CODEERR)
            assert_code_onehot_R7: assert ($onehot0(calc_i ^ stored_i) && (calc_i != stored_i));
    end

endmodule

// File: rtl/ecc_fsm.sv
module ecc_fsm
    import ecc_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    parameter int MAX_BLKS  = 4,
    localparam int IDX_W = $clog2(BLK_BYTES),
    localparam int BLK_W = $clog2(MAX_BLKS + 1),
    localparam int SEL_W = $clog2(MAX_BLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic             cmd_write_i,
    input  logic [IDX_W-1:0] cmd_offs_i,
    input  logic             byte_valid_i,
    input  logic             last_i,
    output logic             start_o,
    output logic             acc_en_o,
    output logic             acc_clr_o,
    output logic             blk_done_o,
    output logic [SEL_W-1:0] blk_sel_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [BLK_W-1:0] blk_cnt_o,
    output logic             wr_mode_o,
    output logic             take_last_o,
    output logic             eval_o,
    output logic             busy_o,
    output logic             done_o
);
    ecc_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [BLK_W-1:0] cnt_q;
    logic             wr_q;
    logic             accept;
    logic             room;

    assign accept = cmd_valid_i && (cmd_offs_i == '0) &&
                    ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign room   = (cnt_q < BLK_W'(MAX_BLKS));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (last_i) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_DONE;
            ST_DONE: state_d = accept ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        start_o     = accept;
        acc_en_o    = 1'b0;
        take_last_o = 1'b0;
        eval_o      = 1'b0;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy_o      = 1'b1;
                acc_en_o    = byte_valid_i && room;
                take_last_o = last_i;
            end
            ST_EVAL: begin
                busy_o = 1'b1;
                eval_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
        blk_done_o = acc_en_o && (idx_q == IDX_W'(BLK_BYTES - 1));
        acc_clr_o  = accept || blk_done_o;
    end

    // byte and block counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            idx_q <= '0;
            cnt_q <= '0;
            wr_q  <= cmd_write_i;
        end else if (acc_en_o) begin
            idx_q <= blk_done_o ? '0 : idx_q + 1'b1;
            if (blk_done_o)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx_o     = idx_q;
    assign blk_cnt_o = cnt_q;
    assign blk_sel_o = cnt_q[SEL_W-1:0];
    assign wr_mode_o = wr_q;

    assert_misaligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid_i && cmd_offs_i != '0) |=> (state_q == ST_IDLE));

    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !byte_valid_i) |=> $stable(idx_q));

    assert_blk_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BLK_W'(MAX_BLKS));

    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !room) |=> ($stable(idx_q) && $stable(cnt_q)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
    import ecc_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    parameter int MAX_BLKS  = 4,
    localparam int IDX_W  = $clog2(BLK_BYTES),
    localparam int POS_W  = IDX_W + 3,
    localparam int CODE_W = 2 * POS_W,
    localparam int BLK_W  = $clog2(MAX_BLKS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid_i,
    input  logic                       cmd_write_i,
    input  logic [IDX_W-1:0]           cmd_offs_i,
    input  logic                       byte_valid_i,
    input  logic [7:0]                 byte_i,
    input  logic                       last_i,
    input  logic [MAX_BLKS*CODE_W-1:0] stored_code_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [BLK_W-1:0]           blk_cnt_o,
    output logic [MAX_BLKS*CODE_W-1:0] code_o,
    output logic [2*MAX_BLKS-1:0]      blk_stat_o,
    output logic [MAX_BLKS*POS_W-1:0]  err_loc_o
);
    localparam int SEL_W = $clog2(MAX_BLKS);

    logic              start, acc_en, acc_clr, blk_done, take_last, eval, wr_mode;
    logic [SEL_W-1:0]  blk_sel;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code_nxt;
    logic [CODE_W-1:0] bank_q [MAX_BLKS];
    logic [MAX_BLKS*CODE_W-1:0] stored_q;
    blk_stat_e         dec_stat [MAX_BLKS];
    logic [POS_W-1:0]  dec_loc  [MAX_BLKS];
    logic [2*MAX_BLKS-1:0]     stat_q;
    logic [MAX_BLKS*POS_W-1:0] loc_q;

    ecc_fsm #(.BLK_BYTES(BLK_BYTES), .MAX_BLKS(MAX_BLKS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_write_i  (cmd_write_i),
        .cmd_offs_i   (cmd_offs_i),
        .byte_valid_i (byte_valid_i),
        .last_i       (last_i),
        .start_o      (start),
        .acc_en_o     (acc_en),
        .acc_clr_o    (acc_clr),
        .blk_done_o   (blk_done),
        .blk_sel_o    (blk_sel),
        .idx_o        (idx),
        .blk_cnt_o    (blk_cnt_o),
        .wr_mode_o    (wr_mode),
        .take_last_o  (take_last),
        .eval_o       (eval),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    hamm_accum #(.IDX_W(IDX_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (acc_clr),
        .en_i       (acc_en),
        .byte_i     (byte_i),
        .idx_i      (idx),
        .code_nxt_o (code_nxt)
    );

    // finished block codes, cleared at every accepted command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < MAX_BLKS; g++) bank_q[g] <= '0;
        end else if (start) begin
            for (int g = 0; g < MAX_BLKS; g++) bank_q[g] <= '0;
        end else if (blk_done) begin
            bank_q[blk_sel] <= code_nxt;
        end
    end

    // spare-area codes captured with the last-block flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stored_q <= '0;
        else if (take_last)
            stored_q <= stored_code_i;
    end

    for (genvar g = 0; g < MAX_BLKS; g++) begin : g_blk
        syn_decode #(.POS_W(POS_W)) u_dec (
            .calc_i   (bank_q[g]),
            .stored_i (stored_q[g*CODE_W +: CODE_W]),
            .stat_o   (dec_stat[g]),
            .loc_o    (dec_loc[g])
        );
        assign code_o[g*CODE_W +: CODE_W] = bank_q[g];
    end

    // per-block status latched in the evaluation state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            loc_q  <= '0;
        end else if (start) begin
            stat_q <= '0;
            loc_q  <= '0;
        end else if (eval) begin
            for (int g = 0; g < MAX_BLKS; g++) begin
                if (!wr_mode && (g < int'(blk_cnt_o))) begin
                    stat_q[2*g +: 2]        <= dec_stat[g];
                    loc_q[g*POS_W +: POS_W] <= dec_loc[g];
                end else begin
                    stat_q[2*g +: 2]        <= BLK_CLEAN;
                    loc_q[g*POS_W +: POS_W] <= '0;
                end
            end
        end
    end

    assign blk_stat_o = stat_q;
    assign err_loc_o  = loc_q;

    assert_wr_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wr_mode) |-> (blk_stat_o == '0 && err_loc_o == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && !start) |=> ($stable(blk_stat_o) && $stable(err_loc_o)));

endmodule

// File: tb/nand_page_ecc_tb_top.sv
module nand_page_ecc_tb_top;
    localparam int NB = 4;
    localparam int CW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid_i = 1'b0, cmd_write_i = 1'b0;
    logic [8:0] cmd_offs_i = '0;
    logic byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic last_i = 1'b0;
    logic [NB*CW-1:0] stored_code_i = '0;
    logic busy_o, done_o;
    logic [2:0] blk_cnt_o;
    logic [NB*CW-1:0] code_o;
    logic [2*NB-1:0] blk_stat_o;
    logic [NB*12-1:0] err_loc_o;

    always #5 clk = ~clk;

    nand_page_ecc dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_write_i(cmd_write_i),
        .cmd_offs_i(cmd_offs_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .last_i(last_i), .stored_code_i(stored_code_i), .busy_o(busy_o), .done_o(done_o),
        .blk_cnt_o(blk_cnt_o), .code_o(code_o), .blk_stat_o(blk_stat_o), .err_loc_o(err_loc_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [7:0]  pg [NB][512];
    logic [23:0] good_code [NB];
    logic [23:0] exp_code  [NB];

    function automatic logic [23:0] ref_code(input int bk);
        logic [23:0] c = '0;
        for (int j = 0; j < 512; j++)
            for (int b = 0; b < 8; b++)
                if (pg[bk][j][b])
                    for (int k = 0; k < 12; k++) begin
                        int p = j * 8 + b;
                        c[2*k + ((p >> k) & 1)] ^= 1'b1;
                    end
        return c;
    endfunction

    // wr, nblk, seed, kind(0 none,1 single,2 double,3 code bit), eblk, pos1, pos2
    localparam int NROWS = 8;
    localparam logic [39:0] VEC [NROWS] = '{
        {1'b1, 3'd4, 8'h3B, 2'd0, 2'd0, 12'h000, 12'h000},
        {1'b0, 3'd4, 8'h3B, 2'd0, 2'd0, 12'h000, 12'h000},
        {1'b0, 3'd2, 8'h51, 2'd1, 2'd1, 12'h000, 12'h000},
        {1'b0, 3'd4, 8'hA7, 2'd1, 2'd3, 12'hFFF, 12'h000},
        {1'b0, 3'd3, 8'h19, 2'd2, 2'd0, 12'h123, 12'h456},
        {1'b0, 3'd1, 8'hC4, 2'd3, 2'd0, 12'd17,  12'h000},
        {1'b1, 3'd1, 8'h00, 2'd0, 2'd0, 12'h000, 12'h000},
        {1'b0, 3'd4, 8'h6E, 2'd1, 2'd2, 12'h804, 12'h000}
    };

    task automatic fill(input logic [7:0] seed);
        for (int bk = 0; bk < NB; bk++)
            for (int j = 0; j < 512; j++)
                pg[bk][j] = 8'((j * seed) + bk * 37 + (j >> 3)) ^ seed;
    endtask

    task automatic run_page(input logic wr, input int nfull, input int extra, input int exp_cnt);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_write_i = wr; cmd_offs_i = '0;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        chk("R1 busy after aligned start", busy_o, 1);
        for (int bk = 0; bk < nfull; bk++)
            for (int j = 0; j < 512; j++) begin
                byte_valid_i = 1'b1; byte_i = pg[bk][j];
                @(negedge clk);
            end
        for (int j = 0; j < extra; j++) begin
            byte_valid_i = 1'b1; byte_i = 8'hA5 ^ 8'(j);
            @(negedge clk);
        end
        byte_valid_i = 1'b0;
        last_i = 1'b1;
        @(negedge clk);
        last_i = 1'b0;
        chk("R9 no done one cycle after last", done_o, 0);
        @(negedge clk);
        chk("R9 done two cycles after last", done_o, 1);
        chk("R9 busy low at done", busy_o, 0);
        chk("R3 block count", blk_cnt_o, exp_cnt);
        @(negedge clk);
        chk("R9 done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset busy", busy_o, 0);
        chk("R11 reset done", done_o, 0);
        chk("R11 reset count", blk_cnt_o, 0);
        chk("R11 reset codes", code_o, 0);
        chk("R11 reset status", {blk_stat_o, err_loc_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NROWS; r++) begin
            logic        wr   = VEC[r][39];
            int          nblk = int'(VEC[r][38:36]);
            logic [1:0]  kind = VEC[r][27:26];
            int          eb   = int'(VEC[r][25:24]);
            logic [11:0] p1   = VEC[r][23:12];
            logic [11:0] p2   = VEC[r][11:0];
            logic [7:0]  est, stv;
            logic [11:0] eloc;
            fill(VEC[r][35:28]);
            for (int bk = 0; bk < NB; bk++) good_code[bk] = ref_code(bk);
            if (kind == 2'd1 || kind == 2'd2) pg[eb][p1 >> 3][p1[2:0]] ^= 1'b1;
            if (kind == 2'd2) pg[eb][p2 >> 3][p2[2:0]] ^= 1'b1;
            stored_code_i = '0;
            for (int bk = 0; bk < NB; bk++) begin
                exp_code[bk] = (bk < nblk) ? ref_code(bk) : 24'h0;
                if (bk < nblk) stored_code_i[bk*CW +: CW] = good_code[bk];
            end
            if (kind == 2'd3) stored_code_i[eb*CW + int'(p1)] ^= 1'b1;
            run_page(wr, nblk, 0, nblk);
            for (int bk = 0; bk < NB; bk++) begin
                chk($sformatf("R2 row %0d block %0d code", r, bk), code_o[bk*CW +: CW], exp_code[bk]);
                est = 8'd0; eloc = '0;
                if (!wr && bk == eb && bk < nblk) begin
                    // R5 clean, R6 correctable, R8 uncorrectable, R7 code error
                    est = (kind == 2'd1) ? 8'd1 : (kind == 2'd2) ? 8'd2 : (kind == 2'd3) ? 8'd3 : 8'd0;
                    if (kind == 2'd1) eloc = p1;
                end
                chk($sformatf("R5 R6 R7 R8 R10 row %0d block %0d status", r, bk), blk_stat_o[2*bk +: 2], est[1:0]);
                chk($sformatf("R6 row %0d block %0d location", r, bk), err_loc_o[bk*12 +: 12], eloc);
            end
            stv = {blk_stat_o, err_loc_o[7:0]} == 16'h0 ? 8'h0 : 8'h1;
            repeat (4) @(negedge clk);
            chk($sformatf("R9 row %0d result held", r),
                {blk_stat_o, err_loc_o, code_o},
                {blk_stat_o, err_loc_o, exp_code[3], exp_code[2], exp_code[1], exp_code[0]});
            chk($sformatf("R9 row %0d no stray done", r), done_o | (stv > 8'h1), 0);
        end

        // R1: misaligned command ignored
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_write_i = 1'b0; cmd_offs_i = 9'h104;
        @(negedge clk);
        cmd_valid_i = 1'b0; cmd_offs_i = '0;
        chk("R1 misaligned command ignored", busy_o, 0);
        @(negedge clk);
        chk("R1 misaligned keeps previous count", blk_cnt_o, 4);

        // R3: trailing partial block not counted
        fill(8'h77);
        good_code[0] = ref_code(0);
        run_page(1'b1, 1, 100, 1);
        chk("R3 partial block excluded from code", code_o, {72'h0, good_code[0]});

        // R4: bytes after the fourth block ignored
        fill(8'h2D);
        for (int bk = 0; bk < NB; bk++) good_code[bk] = ref_code(bk);
        run_page(1'b1, 4, 40, 4);
        chk("R4 extra bytes ignored", code_o,
            {good_code[3], good_code[2], good_code[1], good_code[0]});
        chk("R10 write status zero", {blk_stat_o, err_loc_o}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule